// File: doc/BRIEF.md
# Five-Channel Double-Buffered PWM Timer

This block holds five independent pulse-width channels that share one register port. Each channel keeps a period buffer and a threshold buffer that software writes at any time, a live down-counter, and a live threshold register. The live pair is loaded from the buffers only at defined points: while the channel's load request is held, or when the counter wraps with repeat mode on. A new setting therefore never cuts a running period short.

Per-channel run, load, polarity and repeat flags sit in one shared control word. Channel 0 takes the lowest nibble and the next nibble is left empty. Channels 1 to 4 take the nibbles above it. The last channel has no polarity flag, so its repeat flag sits one bit lower. Time is counted in ticks that an outside divider supplies on one enable line per channel. Each channel drives a pin and a one-cycle period-end strobe.

To start a channel, software first writes its buffers. It then writes the control word with the load flag set and run clear, and finally writes run and repeat with load clear. To stop the channel cleanly, software clears repeat. The channel finishes its current period, clears its own run flag and parks the pin at its idle level.

Top module: `pwm_timer_bank`

## Requirements
- R1: The period buffer of channel c sits at byte offset 0x0C+0x0C*c and the threshold buffer at 0x10+0x0C*c, for c from 0 to 4. Each buffer is CNT_W bits wide (16 or 32). A read returns the last written value truncated to CNT_W bits and zero-extended.
- R2: The control word sits at offset 0x08. Channel 0 uses bits 3:0, and channel c≥1 uses bits 4c+7:4c+4. Within a nibble, bit 0 is run, bit 1 is load, bit 2 is polarity and bit 3 is repeat. Channel 4 has no polarity flag and its repeat flag is bit 22. All other bits read 0, so writing all ones reads back 0x007FFF0F.
- R3: A period buffer value of N-1 gives a period of N ticks. A one-cycle period-end strobe follows each tick on which the counter is at zero.
- R4: A threshold value of N-1-D gives D active ticks per period. An all-ones threshold gives the active level for the whole period. A value of N-1 gives none.
- R5: When a channel's polarity flag is set, its pin is the inverse of its active-high waveform (channels 0 to 3).
- R6: While a channel's load flag is set, its counter and threshold follow the buffers, counting is held and no period-end strobe is raised.
- R7: With repeat set, a counter at zero reloads from the buffers on its tick. A buffer write made during a period takes effect only from the next period.
- R8: When repeat is clear, a counter at zero finishes on its tick: it strobes period end, its run flag reads back 0, its pin holds the idle level (the polarity flag) and no further strobes follow.
- R9: A counter moves only on cycles where its tick enable is high. With one tick every K cycles, a period lasts K*N cycles with K*D active cycles.
- R10: After reset all pins and strobes are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 5 | Per-channel count enable, one bit per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte offset for writes and reads |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for addr (combinational) |
| pwm_out | output | 5 | Channel pins |
| period_end | output | 5 | One-cycle strobe at the end of each period |

## Verification
A register write lands on the clock edge that samples it, so its effect on state is visible in the cycle that follows. A period-end strobe is registered and shows in the cycle after the tick edge that found the counter at zero. The pin follows the counter in that same cycle, and a halted pin takes the idle level in the strobe cycle. The bench samples every output on the falling edge and measures each period as the run of cycles from one strobe up to the next. Stop writes are placed early in a period, so no write sits on a wrap edge, and readback is taken one cycle after the address is driven.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   localparam int NUM_CH   = 5;
   localparam int CTRL_OFS = 8;

   typedef struct packed {
      logic run;
      logic load;
      logic pol;
      logic rpt;
   } ch_ctl_t;

   function automatic int per_ofs(int ch);
      return 12 + 12 * ch;
   endfunction

   function automatic int thr_ofs(int ch);
      return 16 + 12 * ch;
   endfunction

   // nibble 1 of the control word is left empty
   function automatic int nib_base(int ch);
      return (ch == 0) ? 0 : 4 * (ch + 1);
   endfunction

   function automatic bit has_pol(int ch);
      return ch != NUM_CH - 1;
   endfunction

   function automatic int pos_run(int ch);
      return nib_base(ch);
   endfunction

   function automatic int pos_load(int ch);
      return nib_base(ch) + 1;
   endfunction

   function automatic int pos_pol(int ch);
      return nib_base(ch) + 2;
   endfunction

   // last channel has its repeat flag one bit lower
   function automatic int pos_rpt(int ch);
      return nib_base(ch) + (has_pol(ch) ? 3 : 2);
   endfunction

   function automatic logic [31:0] ctrl_mask();
      logic [31:0] m = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         m = m | (32'd1 << pos_run(c)) | (32'd1 << pos_load(c)) | (32'd1 << pos_rpt(c));
         if (has_pol(c)) m = m | (32'd1 << pos_pol(c));
      end
      return m;
   endfunction

endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
   import ptmr_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int AW    = 8,
   parameter int DW    = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [AW-1:0]                  addr,
   input  logic [DW-1:0]                  wdata,
   input  logic [NUM_CH-1:0]              halt,
   output logic [DW-1:0]                  rdata,
   output logic [NUM_CH-1:0][CNT_W-1:0]   per_buf,
   output logic [NUM_CH-1:0][CNT_W-1:0]   thr_buf,
   output ch_ctl_t [NUM_CH-1:0]           ctl
);

   localparam logic [DW-1:0] MASK   = DW'(ctrl_mask());
   localparam logic [AW-1:0] CTRL_A = AW'(CTRL_OFS);

   logic [DW-1:0]             ctrl_q;
   logic [DW-1:0]             ctrl_nx;
   logic                      ctrl_wr;
   logic [NUM_CH:0][DW-1:0]   clr_acc;
   logic [NUM_CH:0][DW-1:0]   rd_acc;

   assign ctrl_wr   = wr_en && (addr == CTRL_A);
   assign clr_acc[0] = '0;
   assign rd_acc[0]  = (addr == CTRL_A) ? ctrl_q : '0;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [AW-1:0] PER_A = AW'(per_ofs(i));
      localparam logic [AW-1:0] THR_A = AW'(thr_ofs(i));
      localparam logic [DW-1:0] RUN_M = DW'(1) << pos_run(i);

      logic [CNT_W-1:0] per_q;
      logic [CNT_W-1:0] thr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            per_q <= '0;
            thr_q <= '0;
         end else if (wr_en) begin
            if (addr == PER_A) per_q <= wdata[CNT_W-1:0];
            if (addr == THR_A) thr_q <= wdata[CNT_W-1:0];
         end
      end

      assign per_buf[i]  = per_q;
      assign thr_buf[i]  = thr_q;
      assign clr_acc[i+1] = clr_acc[i] | (halt[i] ? RUN_M : '0);
      assign rd_acc[i+1]  = rd_acc[i]
                          | ((addr == PER_A) ? DW'(per_q) : '0)
                          | ((addr == THR_A) ? DW'(thr_q) : '0);

      assign ctl[i].run  = ctrl_q[pos_run(i)];
      assign ctl[i].load = ctrl_q[pos_load(i)];
      assign ctl[i].rpt  = ctrl_q[pos_rpt(i)];
      if (has_pol(i)) begin : g_pol
         assign ctl[i].pol = ctrl_q[pos_pol(i)];
      end else begin : g_nopol
         assign ctl[i].pol = 1'b0;
      end
   end

   // a software write wins over a self-clear in the same cycle
   assign ctrl_nx = ctrl_wr ? (wdata & MASK) : (ctrl_q & ~clr_acc[NUM_CH]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_nx;
   end

   assign rdata = rd_acc[NUM_CH];

endmodule

// File: rtl/ptmr_chan.sv
module ptmr_chan #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             load,
   input  logic             pol,
   input  logic             rpt,
   input  logic [CNT_W-1:0] per_buf,
   input  logic [CNT_W-1:0] thr_buf,
   output logic             pin,
   output logic             pend,
   output logic             halt
);

   localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] thr_q;
   logic             pend_q;
   logic             at_zero;
   logic             wrap;
   logic             act;

   assign at_zero = (cnt_q == '0);
   assign wrap    = run && !load && tick && at_zero;
   assign halt    = wrap && !rpt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         thr_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= wrap;
         if (load) begin
            cnt_q <= per_buf;
            thr_q <= thr_buf;
         end else if (run && tick) begin
            if (!at_zero) begin
               cnt_q <= cnt_q - CNT_W'(1);
            end else if (rpt) begin
               cnt_q <= per_buf;
               thr_q <= thr_buf;
            end
         end
      end
   end

   // all-ones threshold stands for -1: active for the whole period
   assign act  = run && ((thr_q == ALL1) || (cnt_q > thr_q));
   assign pin  = act ^ pol;
   assign pend = pend_q;

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
   import ptmr_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int AW    = 8,
   parameter int DW    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        tick_en,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   output logic [4:0]        pwm_out,
   output logic [4:0]        period_end
);

   if (CNT_W != 16 && CNT_W != 32) begin : g_bad_cnt_w
      $error("pwm_timer_bank: CNT_W must be 16 or 32");
   end
   if (DW < CNT_W || DW < 24) begin : g_bad_dw
      $error("pwm_timer_bank: DW too narrow");
   end
   if (AW < 7) begin : g_bad_aw
      $error("pwm_timer_bank: AW too narrow for the register map");
   end
   if (NUM_CH != 5) begin : g_bad_nch
      $error("pwm_timer_bank: port widths assume five channels");
   end

   logic [NUM_CH-1:0][CNT_W-1:0] per_buf;
   logic [NUM_CH-1:0][CNT_W-1:0] thr_buf;
   ch_ctl_t [NUM_CH-1:0]         ctl;
   logic [NUM_CH-1:0]            halt;
   logic [NUM_CH-1:0]            ch_run;
   logic [NUM_CH-1:0]            ch_load;
   logic [NUM_CH-1:0]            ch_pol;
   logic [NUM_CH-1:0]            ch_rpt;

   ptmr_regs #(.CNT_W(CNT_W), .AW(AW), .DW(DW)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .halt    (halt),
      .rdata   (rdata),
      .per_buf (per_buf),
      .thr_buf (thr_buf),
      .ctl     (ctl)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      assign ch_run[i]  = ctl[i].run;
      assign ch_load[i] = ctl[i].load;
      assign ch_pol[i]  = ctl[i].pol;
      assign ch_rpt[i]  = ctl[i].rpt;

      ptmr_chan #(.CNT_W(CNT_W)) i_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick_en[i]),
         .run     (ctl[i].run),
         .load    (ctl[i].load),
         .pol     (ctl[i].pol),
         .rpt     (ctl[i].rpt),
         .per_buf (per_buf[i]),
         .thr_buf (thr_buf[i]),
         .pin     (pwm_out[i]),
         .pend    (period_end[i]),
         .halt    (halt[i])
      );
   end

endmodule

// File: rtl/pwm_timer_bank_chk.sv
module pwm_timer_bank_chk #(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic [4:0]    tick_en,
   input logic          wr_en,
   input logic [AW-1:0] addr,
   input logic [DW-1:0] rdata,
   input logic [4:0]    pwm_out,
   input logic [4:0]    period_end,
   input logic [4:0]    ch_run,
   input logic [4:0]    ch_load,
   input logic [4:0]    ch_pol,
   input logic [4:0]    ch_rpt
);

   localparam logic [DW-1:0] USED = DW'(32'h007F_FF0F);

   p_ctrl_unused_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == AW'(8)) |-> ((rdata & ~USED) == '0));

   for (genvar i = 0; i < 5; i++) begin : g_p
      p_end_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
         period_end[i] |-> $past(tick_en[i]));

      p_load_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
         period_end[i] |-> !$past(ch_load[i]));

      p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_run[i] |-> (pwm_out[i] == ch_pol[i]));

      p_stop_clears_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (period_end[i] && !$past(ch_rpt[i]) && !$past(wr_en)) |-> !ch_run[i]);
   end

endmodule

bind pwm_timer_bank pwm_timer_bank_chk #(.AW(AW), .DW(DW)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_en    (tick_en),
   .wr_en      (wr_en),
   .addr       (addr),
   .rdata      (rdata),
   .pwm_out    (pwm_out),
   .period_end (period_end),
   .ch_run     (ch_run),
   .ch_load    (ch_load),
   .ch_pol     (ch_pol),
   .ch_rpt     (ch_rpt)
);

// File: tb/test_pwm_timer_bank.sv
module test_pwm_timer_bank;

   localparam int CW = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  tick_en = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [4:0]  pwm_out;
   logic [4:0]  period_end;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   int tick_k = 1;
   int tick_ph = 0;
   bit done = 1'b0;

   pwm_timer_bank #(.CNT_W(CW)) i_pwm_timer_bank (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .period_end(period_end)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (tick_ph + 1 >= tick_k) begin
         tick_ph = 0;
         tick_en = 5'h1F;
      end else begin
         tick_ph = tick_ph + 1;
         tick_en = '0;
      end
   end

   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic bit pick(logic [4:0] v, int n);
      logic [2:0] k = n[2:0];
      return v[k];
   endfunction

   function automatic int nbase(int ch);
      return (ch == 0) ? 0 : 4 * (ch + 1);
   endfunction

   function automatic logic [31:0] ctl_word(int ch, bit st, bit ld, bit pl, bit rp);
      logic [31:0] w = '0;
      w = w | (32'(st) << nbase(ch)) | (32'(ld) << (nbase(ch) + 1));
      if (ch < 4) w = w | (32'(pl) << (nbase(ch) + 2));
      w = w | (32'(rp) << (nbase(ch) + ((ch == 4) ? 2 : 3)));
      return w;
   endfunction

   function automatic logic [31:0] thr_for(int n, int d);
      return (d == n) ? 32'hFFFF_FFFF : 32'(n - 1 - d);
   endfunction

   function automatic logic [7:0] per_a(int ch);
      return 8'(12 + 12 * ch);
   endfunction

   function automatic logic [7:0] thr_a(int ch);
      return 8'(16 + 12 * ch);
   endfunction

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic setup(int ch, int n, int d, bit pl);
      wr(per_a(ch), 32'(n - 1));
      wr(thr_a(ch), thr_for(n, d));
      wr(8'h08, ctl_word(ch, 1'b0, 1'b1, pl, 1'b0));
      wr(8'h08, ctl_word(ch, 1'b1, 1'b0, pl, 1'b1));
   endtask

   task automatic wait_pe(int ch, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (pick(period_end, ch)) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   // window: from one strobe cycle up to the cycle before the next strobe
   task automatic measure(int ch, bit ipol, output bit ok, output int len, output int act);
      len = 0; act = 0;
      wait_pe(ch, ok);
      if (ok) begin
         ok = 1'b0;
         for (int i = 0; i < 4000; i++) begin
            if (pick(pwm_out, ch) != ipol) act++;
            len++;
            @(negedge clk);
            if (pick(period_end, ch)) begin
               ok = 1'b1;
               break;
            end
         end
      end
   endtask

   task automatic stop_check(int ch, bit pl, int n, int k);
      bit ok;
      bit seen = 1'b0;
      bit ipol = (ch == 4) ? 1'b0 : pl;
      logic [31:0] rv;
      wr(8'h08, ctl_word(ch, 1'b1, 1'b0, pl, 1'b0));
      wait_pe(ch, ok);
      chk(ok, "R8", "final strobe after repeat cleared", 32'(ok), 1);
      chk(pick(pwm_out, ch) == ipol, "R8", "pin idle level in final strobe cycle",
          32'(pick(pwm_out, ch)), 32'(ipol));
      rd(8'h08, rv);
      chk(((rv >> nbase(ch)) & 32'd1) == 0, "R8", "run flag self-cleared",
          (rv >> nbase(ch)) & 32'd1, 0);
      for (int i = 0; i < 2 * n * k + 4; i++) begin
         @(negedge clk);
         if (pick(period_end, ch)) seen = 1'b1;
         if (pick(pwm_out, ch) != ipol) seen = 1'b1;
      end
      chk(!seen, "R8", "no strobe and steady pin once halted", 32'(seen), 0);
      wr(8'h08, 32'h0);
   endtask

   task automatic run_case(int ch, int n, int d, bit pl, int k);
      bit ok;
      int len;
      int act;
      bit ipol = (ch == 4) ? 1'b0 : pl;
      tick_k = k;
      setup(ch, n, d, pl);
      measure(ch, ipol, ok, len, act);
      chk(ok, "R3", "two period strobes seen", 32'(ok), 1);
      chk(len == n * k, "R3", $sformatf("ch%0d period cycles (R9 k=%0d)", ch, k), len, n * k);
      chk(act == d * k, "R4", $sformatf("ch%0d active cycles pol=%0d (R5)", ch, pl), act, d * k);
      stop_check(ch, pl, n, k);
   endtask

   initial begin
      logic [31:0] rv;
      bit ok;
      int t0;
      int len;
      int act;
      void'($urandom(32'd4711));

      repeat (3) @(negedge clk);
      // R10: reset state
      chk(pwm_out == 5'd0, "R10", "pins in reset", 32'(pwm_out), 0);
      chk(period_end == 5'd0, "R10", "strobes in reset", 32'(period_end), 0);
      rst_n = 1'b1;
      rd(8'h08, rv);
      chk(rv == 0, "R10", "control after reset", rv, 0);
      rd(thr_a(2), rv);
      chk(rv == 0, "R10", "threshold buffer after reset", rv, 0);

      // R1: buffer map and zero extension
      for (int c = 0; c < 5; c++) begin
         wr(per_a(c), 32'hA5A0_0000 + 32'(c * 257 + 3));
         wr(thr_a(c), 32'h5A50_0000 + 32'(c * 31 + 7));
      end
      for (int c = 0; c < 5; c++) begin
         rd(per_a(c), rv);
         chk(rv == 32'(c * 257 + 3), "R1", $sformatf("period buffer ch%0d", c), rv, c * 257 + 3);
         rd(thr_a(c), rv);
         chk(rv == 32'(c * 31 + 7), "R1", $sformatf("threshold buffer ch%0d", c), rv, c * 31 + 7);
      end

      // R2 layout readback, R6 hold while loading
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, rv);
      chk(rv == 32'h007F_FF0F, "R2", "control readback mask", rv, 32'h007F_FF0F);
      ok = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (period_end != 5'd0) ok = 1'b1;
      end
      chk(!ok, "R6", "no strobe while load flags held", 32'(ok), 0);
      wr(8'h08, 32'h0);

      // directed corners
      run_case(0, 5, 5, 1'b0, 1);   // R4 all-ones threshold
      run_case(0, 5, 0, 1'b0, 1);   // R4 no active ticks
      run_case(1, 5, 2, 1'b1, 1);   // R5 polarity
      run_case(4, 4, 1, 1'b0, 1);   // R2 channel 4 repeat flag at bit 22
      run_case(3, 3, 1, 1'b0, 4);   // R9 sparse ticks

      // R7: buffer write during a period applies from the next one
      tick_k = 1;
      setup(2, 6, 2, 1'b0);
      wait_pe(2, ok);
      t0 = cyc;
      wr(per_a(2), 32'd9);
      wr(thr_a(2), thr_for(10, 3));
      wait_pe(2, ok);
      chk(ok && (cyc - t0) == 6, "R7", "current period keeps old length", cyc - t0, 6);
      measure(2, 1'b0, ok, len, act);
      chk(len == 10, "R7", "next period uses new length", len, 10);
      chk(act == 3, "R7", "next period uses new threshold", act, 3);
      stop_check(2, 1'b0, 10, 1);

      // random mix
      for (int it = 0; it < 20; it++) begin
         int ch = int'($urandom % 5);
         int n  = 3 + int'($urandom % 30);
         int d  = int'($urandom % (n + 1));
         bit pl = (ch < 4) ? bit'($urandom % 2) : 1'b0;
         int k  = 1 + int'($urandom % 3);
         run_case(ch, n, d, pl, k);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

endmodule